// File: doc/BRIEF.md
# Exact Power-of-Two Scaler for a Three-Residue Number System

This block accepts an unsigned integer X held as three residues, one for each of the pairwise coprime moduli 2^n-1, 2^n and 2^n+1. It divides X by the middle modulus 2^n and rounds down, with no error. The quotient comes out in two forms: as three fresh residues over the same moduli, and as a plain 2n-bit binary number. A downstream stage that needs the binary value therefore needs no separate reverse converter.

The datapath contains only adders, comparators and multiplexers. There is no table and no memory. First it forms the quotient's residues modulo 2^n-1 and 2^n+1 by modular subtraction. Then it combines these two residues into the binary quotient using a two-modulus Chinese-remainder step. The weight in that step is a multiplication by a power of two modulo 2^n+1, built as a chain of modular doublings.

Three parameters place optional register cuts after the residue front end, after the weight chain and at the output. The valid strobe passes through the same cuts, so the latency is fixed and equals the number of cuts enabled.

Top module: `rns_pow2_scaler`

## Requirements
- R1: When out_valid is high, out_quot equals floor(X / 2^n), where X is the unique value in [0, (2^n-1)·2^n·(2^n+1)) whose residues were presented with the matching in_valid.
- R2: When out_valid is high, out_rlo equals floor(X / 2^n) mod (2^n-1), always in the range 0 to 2^n-2.
- R3: When out_valid is high, out_rmid equals floor(X / 2^n) mod 2^n.
- R4: When out_valid is high, out_rhi equals floor(X / 2^n) mod (2^n+1), in the range 0 to 2^n.
- R5: out_valid is in_valid delayed by exactly CUT_FRONT+CUT_MID+CUT_OUT clock cycles, and a cycle with in_valid low never produces a cycle with out_valid high.
- R6: While rst_n is low, out_valid is low. When the output cut is enabled, out_quot also reads zero during reset, whatever the inputs.
- R7: X = 0 yields all outputs zero. X = M-1 yields out_quot = 2^(2n)-2, out_rlo = 2^n-2, out_rmid = 2^n-2 and out_rhi = 2^n.
- R8: For X an exact multiple of 2^n (in_rmid = 0), out_quot equals X / 2^n exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input residues are valid this cycle |
| in_rlo | input | N | Residue of X modulo 2^n-1 |
| in_rmid | input | N | Residue of X modulo 2^n |
| in_rhi | input | N+1 | Residue of X modulo 2^n+1 |
| out_valid | output | 1 | Output quotient is valid this cycle |
| out_rlo | output | N | Quotient modulo 2^n-1 |
| out_rmid | output | N | Quotient modulo 2^n |
| out_rhi | output | N+1 | Quotient modulo 2^n+1 |
| out_quot | output | 2N | Quotient in binary |

## Verification
The bench builds the block with N = 4, the front and output cuts enabled and the middle cut disabled. With N = 4 the dynamic range has only 4080 values, so every X is swept in full, with idle gaps mixed in. This reaches both wrap-around corners of the modular subtractors and the full range of the doubling chain. With a latency of two, the bench covers both a registered and an unregistered boundary between stages, as well as the reset value of a registered output.

// File: rtl/rns_scale_pkg.sv
package rns_scale_pkg;

   localparam int unsigned MIN_N = 2;
   localparam int unsigned MAX_N = 16;

   // Number of register cuts enabled; each flag is 0 or 1.
   function automatic int unsigned cut_total(input int unsigned f,
                                             input int unsigned m,
                                             input int unsigned o);
      return f + m + o;
   endfunction

endpackage

// File: rtl/rns_stage_reg.sv
module rns_stage_reg #(
   parameter int unsigned W  = 8,
   parameter int unsigned EN = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d_data,
   output logic         q_valid,
   output logic [W-1:0] q_data
);

   generate
      if (EN != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid <= 1'b0;
               q_data  <= '0;
            end else begin
               q_valid <= d_valid;
               q_data  <= d_data;
            end
         end
      end else begin : g_wire
         assign q_valid = d_valid;
         assign q_data  = d_data;
      end
   endgenerate

endmodule

// File: rtl/rns_sub_mod_fermat.sv
// y = (x_min - x_sub) mod (2^N + 1); both operands below 2^N + 1.
module rns_sub_mod_fermat #(
   parameter int unsigned N = 8
) (
   input  logic [N:0] x_min,
   input  logic [N:0] x_sub,
   output logic [N:0] y
);

   localparam logic [N+1:0] MOD_HI = (N+2)'((1 << N) + 1);

   logic [N+1:0] diff;
   logic [N+1:0] wrap;

   always_comb begin
      diff = {1'b0, x_min} - {1'b0, x_sub};
      wrap = diff + MOD_HI;
      y    = diff[N+1] ? wrap[N:0] : diff[N:0];
   end

endmodule

// File: rtl/rns_residue_fold.sv
// Removes the discarded residue: residues of (X - rmid) / 2^N.
module rns_residue_fold #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] r_lo,
   input  logic [N-1:0] r_mid,
   input  logic [N:0]   r_hi,
   output logic [N-1:0] y_lo,
   output logic [N:0]   y_hi
);

   logic [N:0]   eac_sum;
   logic [N-1:0] eac_fold;

   // 2^N = 1 mod (2^N-1): quotient residue is r_lo - r_mid, end-around carry.
   always_comb begin
      eac_sum  = {1'b0, r_lo} + {1'b0, ~r_mid};
      eac_fold = eac_sum[N-1:0] + N'(eac_sum[N]);
      y_lo     = (&eac_fold) ? '0 : eac_fold;
   end

   // 2^N = -1 mod (2^N+1): quotient residue is r_mid - r_hi.
   rns_sub_mod_fermat #(.N(N)) u_hi_sub (
      .x_min ({1'b0, r_mid}),
      .x_sub (r_hi),
      .y     (y_hi)
   );

endmodule

// File: rtl/rns_crt_weight.sv
// k = (b - a) * 2^(N-1) mod (2^N+1); 2^(N-1) is the inverse of 2^N-1 there.
module rns_crt_weight #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] a,
   input  logic [N:0]   b,
   output logic [N:0]   k
);

   localparam int unsigned STEPS  = N - 1;
   localparam logic [N+1:0] MOD_HI = (N+2)'((1 << N) + 1);

   logic [N:0] chain [0:STEPS];

   rns_sub_mod_fermat #(.N(N)) u_diff (
      .x_min (b),
      .x_sub ({1'b0, a}),
      .y     (chain[0])
   );

   generate
      for (genvar s = 1; s <= STEPS; s++) begin : g_dbl
         logic [N+1:0] twice;
         logic [N+1:0] trimmed;
         assign twice   = {chain[s-1], 1'b0};
         assign trimmed = twice - MOD_HI;
         assign chain[s] = (twice >= MOD_HI) ? trimmed[N:0] : twice[N:0];
      end
   endgenerate

   assign k = chain[STEPS];

endmodule

// File: rtl/rns_crt_rebuild.sv
// y = a + (2^N - 1) * k, exact below (2^N-1)(2^N+1).
module rns_crt_rebuild #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0]   a,
   input  logic [N:0]     k,
   output logic [2*N-1:0] y
);

   localparam int unsigned AW = 2 * N + 2;

   logic [AW-1:0] acc;

   always_comb begin
      acc = (AW'(k) << N) + AW'(a) - AW'(k);
      y   = acc[2*N-1:0];
   end

endmodule

// File: rtl/rns_pow2_scaler.sv
module rns_pow2_scaler #(
   parameter int unsigned N         = 8,
   parameter int unsigned CUT_FRONT = 1,
   parameter int unsigned CUT_MID   = 0,
   parameter int unsigned CUT_OUT   = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N-1:0]   in_rlo,
   input  logic [N-1:0]   in_rmid,
   input  logic [N:0]     in_rhi,
   output logic           out_valid,
   output logic [N-1:0]   out_rlo,
   output logic [N-1:0]   out_rmid,
   output logic [N:0]     out_rhi,
   output logic [2*N-1:0] out_quot
);

   import rns_scale_pkg::*;

   localparam int unsigned LATENCY = cut_total(CUT_FRONT, CUT_MID, CUT_OUT);
   localparam int unsigned WA      = N;
   localparam int unsigned WB      = N + 1;
   localparam int unsigned WQ      = 2 * N;
   localparam int unsigned W1      = WA + WB;
   localparam int unsigned W2      = WA + WB + WB;
   localparam int unsigned W3      = WA + WB + WQ;

   generate
      if (N < MIN_N || N > MAX_N) begin : g_bad_n
         $error("rns_pow2_scaler: N out of supported range");
      end
      if (CUT_FRONT > 1 || CUT_MID > 1 || CUT_OUT > 1) begin : g_bad_cut
         $error("rns_pow2_scaler: cut flags must be 0 or 1");
      end
   endgenerate

   // Front: residues of the quotient modulo 2^N-1 and 2^N+1.
   logic [WA-1:0] f_a;
   logic [WB-1:0] f_b;

   rns_residue_fold #(.N(N)) u_fold (
      .r_lo  (in_rlo),
      .r_mid (in_rmid),
      .r_hi  (in_rhi),
      .y_lo  (f_a),
      .y_hi  (f_b)
   );

   logic          s1_v;
   logic [W1-1:0] s1_d;

   rns_stage_reg #(.W(W1), .EN(CUT_FRONT)) u_cut_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d_data  ({f_a, f_b}),
      .q_valid (s1_v),
      .q_data  (s1_d)
   );

   logic [WA-1:0] s1_a;
   logic [WB-1:0] s1_b;
   logic [WB-1:0] s1_k;

   assign {s1_a, s1_b} = s1_d;

   rns_crt_weight #(.N(N)) u_weight (
      .a (s1_a),
      .b (s1_b),
      .k (s1_k)
   );

   logic          s2_v;
   logic [W2-1:0] s2_d;

   rns_stage_reg #(.W(W2), .EN(CUT_MID)) u_cut_mid (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (s1_v),
      .d_data  ({s1_a, s1_b, s1_k}),
      .q_valid (s2_v),
      .q_data  (s2_d)
   );

   logic [WA-1:0] s2_a;
   logic [WB-1:0] s2_b;
   logic [WB-1:0] s2_k;
   logic [WQ-1:0] s2_y;

   assign {s2_a, s2_b, s2_k} = s2_d;

   rns_crt_rebuild #(.N(N)) u_rebuild (
      .a (s2_a),
      .k (s2_k),
      .y (s2_y)
   );

   logic          s3_v;
   logic [W3-1:0] s3_d;

   rns_stage_reg #(.W(W3), .EN(CUT_OUT)) u_cut_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (s2_v),
      .d_data  ({s2_a, s2_b, s2_y}),
      .q_valid (s3_v),
      .q_data  (s3_d)
   );

   assign out_valid                    = s3_v;
   assign {out_rlo, out_rhi, out_quot} = s3_d;
   assign out_rmid                     = out_quot[N-1:0];

endmodule

// File: rtl/rns_pow2_scaler_chk.sv
module rns_pow2_scaler_chk #(
   parameter int unsigned N       = 8,
   parameter int unsigned LATENCY = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           out_valid,
   input logic [N-1:0]   out_rlo,
   input logic [N:0]     out_rhi,
   input logic [2*N-1:0] out_quot
);

   localparam longint M_LO   = (longint'(1) << N) - 1;
   localparam longint M_HI   = (longint'(1) << N) + 1;
   localparam longint Q_LIM  = (longint'(1) << (2 * N)) - 1;

   logic [3:0] v_hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_hist <= '0;
      else        v_hist <= {v_hist[2:0], in_valid};
   end

   generate
      if (LATENCY == 0) begin : g_lat0
         // R5
         latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
      end else begin : g_latn
         // R5
         latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == v_hist[LATENCY-1]);
      end
   endgenerate

   // R1
   quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (longint'(out_quot) < Q_LIM));

   // R2
   rlo_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (longint'(out_quot) % M_LO == longint'(out_rlo)));

   // R4
   rhi_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (longint'(out_quot) % M_HI == longint'(out_rhi)));

endmodule

bind rns_pow2_scaler rns_pow2_scaler_chk #(.N(N), .LATENCY(LATENCY)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_rlo   (out_rlo),
   .out_rhi   (out_rhi),
   .out_quot  (out_quot)
);

// File: tb/rns_pow2_scaler_bench.sv
module rns_pow2_scaler_bench;

   localparam int N    = 4;
   localparam int LAT  = 2;
   localparam int MLO  = (1 << N) - 1;
   localparam int MMID = (1 << N);
   localparam int MHI  = (1 << N) + 1;
   localparam int MR   = MLO * MMID * MHI;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [N-1:0]   in_rlo = '0;
   logic [N-1:0]   in_rmid = '0;
   logic [N:0]     in_rhi = '0;
   logic           out_valid;
   logic [N-1:0]   out_rlo;
   logic [N-1:0]   out_rmid;
   logic [N:0]     out_rhi;
   logic [2*N-1:0] out_quot;

   int vectors = 0;
   int misses  = 0;
   int cur_x   = 0;
   bit done    = 1'b0;

   bit md_v [LAT];
   int md_x [LAT];

   rns_pow2_scaler #(.N(N), .CUT_FRONT(1), .CUT_MID(0), .CUT_OUT(1)) u_rns_pow2_scaler (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_rlo    (in_rlo),
      .in_rmid   (in_rmid),
      .in_rhi    (in_rhi),
      .out_valid (out_valid),
      .out_rlo   (out_rlo),
      .out_rmid  (out_rmid),
      .out_rhi   (out_rhi),
      .out_quot  (out_quot)
   );

   always #4 clk = ~clk;

   // Behavioural reference: a plain delay line of (valid, X).
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) begin
            md_v[i] <= 1'b0;
            md_x[i] <= 0;
         end
      end else begin
         for (int i = LAT - 1; i > 0; i--) begin
            md_v[i] <= md_v[i-1];
            md_x[i] <= md_x[i-1];
         end
         md_v[0] <= in_valid;
         md_x[0] <= cur_x;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic compare_now();
      int x;
      int q;
      check("R5 out_valid", int'(out_valid), int'(md_v[LAT-1]));
      if (md_v[LAT-1]) begin
         x = md_x[LAT-1];
         q = x / MMID;
         check("R1 out_quot", int'(out_quot), q);
         check("R2 out_rlo", int'(out_rlo), q % MLO);
         check("R3 out_rmid", int'(out_rmid), q % MMID);
         check("R4 out_rhi", int'(out_rhi), q % MHI);
         if (x == 0) begin
            check("R7 zero quot", int'(out_quot), 0);
            check("R7 zero rhi", int'(out_rhi), 0);
         end
         if (x == MR - 1) begin
            check("R7 top quot", int'(out_quot), (1 << (2 * N)) - 2);
            check("R7 top rlo", int'(out_rlo), MMID - 2);
            check("R7 top rmid", int'(out_rmid), MMID - 2);
            check("R7 top rhi", int'(out_rhi), MMID);
         end
         if (x % MMID == 0) check("R8 exact quot", int'(out_quot) * MMID, x);
      end
   endtask

   task automatic apply(input int x, input bit v);
      @(negedge clk);
      compare_now();
      cur_x    = x;
      in_rlo   = N'(x % MLO);
      in_rmid  = N'(x % MMID);
      in_rhi   = (N+1)'(x % MHI);
      in_valid = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL R5 watchdog: actual run unfinished expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      // Reset dominates live input.
      cur_x    = MR - 1;
      in_rlo   = N'((MR - 1) % MLO);
      in_rmid  = N'((MR - 1) % MMID);
      in_rhi   = (N+1)'((MR - 1) % MHI);
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R6 reset out_valid", int'(out_valid), 0);
      check("R6 reset out_quot", int'(out_quot), 0);
      in_valid = 1'b0;
      rst_n    = 1'b1;

      // Exhaustive sweep with idle gaps.
      for (int x = 0; x < MR; x++) begin
         if (x % 7 == 3) apply((x * 5) % MR, 1'b0);
         apply(x, 1'b1);
      end

      // Corners: extremes, multiples of 2^n, back-to-back.
      apply(0, 1'b1);
      apply(MR - 1, 1'b1);
      apply(0, 1'b1);
      for (int j = 0; j < MR / MMID; j += 13) apply(j * MMID, 1'b1);
      apply(MR - MMID, 1'b1);

      // Random mix with random idle cycles.
      for (int r = 0; r < 400; r++) apply(int'($urandom % MR), 1'($urandom % 4 != 0));

      for (int d = 0; d < LAT + 2; d++) apply(0, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule